// File: doc/BRIEF.md
# I2C Master Bus Sequencer

This block is the bus-facing engine of an I2C controller that carries out exactly one bus operation per host request. The six operations are START, repeated START, STOP, transmit one byte (with the slave's acknowledge sampled on the ninth clock), receive one byte, and drive a single acknowledge bit after a received byte. The host raises a one-cycle request pulse. The matching command bit stays set while the operation runs and clears by itself when the operation ends. A completion flag then stays set until the host clears it.

The bit clock comes from a programmable divider. A quarter-bit tick fires every `div_i + 1` system clocks. Each SCL low phase and each SCL high phase lasts two ticks. Every operation is built from four-tick slots. Only one operation can own the engine at a time. A request or buffer write that arrives while the engine is busy is dropped, and a sticky collision flag records it. The block drives only pull-low enables for SCL and SDA. It reads both lines back through an optional synchronizer and holds its own high phase while another device keeps SCL low.

Top module: `i2c_cond_seq`

## Requirements
- R1: During a byte or acknowledge transfer, SCL rises every 4*(div_i+1) system clocks and stays high for 2*(div_i+1) system clocks.
- R2: START pulls SDA low while SCL is high and then pulls SCL low. On completion, st_start reads 1 and st_stop reads 0.
- R3: STOP releases SCL with SDA held low and then releases SDA while SCL is high. On completion, st_stop reads 1 and st_start reads 0.
- R4: A repeated START issued with SCL low releases SDA, then releases SCL, then pulls SDA low while SCL is high. The bus shows a START condition and no data bit.
- R5: A write puts its byte on SDA MSB first, changing SDA only while SCL is low. On the ninth clock it releases SDA and samples it. ack_stat then reads 1 if the slave did not acknowledge (SDA high) and 0 if it did.
- R6: A receive keeps SDA released for eight clocks. It shifts the sampled bits in MSB first, and the byte appears on rd_data when the operation ends.
- R7: An acknowledge operation drives ack_data for one clock: 0 pulls SDA low (ACK) and 1 leaves it released (NACK).
- R8: cmd_bits holds bit 0 for START, bit 1 for repeated START, bit 2 for STOP, bit 3 for receive and bit 4 for acknowledge. An accepted request sets its bit; completion clears it. idle is 1 exactly when no command bit and no tx_busy is set.
- R9: A request or write made while idle is 0 has no effect on the bus, cmd_bits or rd_data. It sets wcol, which stays set until wcol_clr.
- R10: If several requests arrive in the same cycle while idle, only the one with the highest priority is accepted. The order is START, repeated START, STOP, receive, acknowledge, write. The others are dropped and set wcol.
- R11: irq is set when any operation completes and stays set until irq_clr.
- R12: bus_free reads 1 when st_stop is 1 or when both status bits are 0.
- R13: When SCL stays low after the block releases it, the block neither samples nor advances until SCL reads high. The operation then completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Quarter-bit divider value |
| req_start | input | 1 | Request a START |
| req_rstart | input | 1 | Request a repeated START |
| req_stop | input | 1 | Request a STOP |
| req_recv | input | 1 | Request a byte receive |
| req_ack | input | 1 | Request an acknowledge bit |
| wr_en | input | 1 | Buffer write; starts a byte transmit |
| wr_data | input | DW | Byte to transmit |
| ack_data | input | 1 | Acknowledge value to send, 1 = NACK |
| wcol_clr | input | 1 | Clear the collision flag |
| irq_clr | input | 1 | Clear the completion flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rd_data | output | DW | Data buffer (last written or received byte) |
| ack_stat | output | 1 | Slave acknowledge of last transmit, 1 = not acknowledged |
| cmd_bits | output | 5 | Self-clearing command bits |
| tx_busy | output | 1 | Transmit in progress |
| idle | output | 1 | No operation pending or running |
| wcol | output | 1 | Sticky collision flag |
| irq | output | 1 | Sticky completion flag |
| st_start | output | 1 | START was the last condition generated |
| st_stop | output | 1 | STOP was the last condition generated |
| bus_free | output | 1 | Bus may be taken |

## Verification
A bus monitor turns the SCL/SDA pins into START, STOP and data-bit events. A scoreboard compares those events against what each request should produce. The request stream covers a plain START, two transmits with the slave acknowledging and not acknowledging, a repeated START, and two receives with different byte values, each followed by an acknowledge and a non-acknowledge. These patterns separate bit order, acknowledge sampling and driven-versus-released SDA. Period and high-time measurements at two divider values confirm the clock formula. Mid-operation writes and requests, same-cycle collisions and a long external SCL hold show that dropped requests leave the bus unchanged and that the engine waits instead of sampling early.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_START  = 3'd1,
      OP_RSTART = 3'd2,
      OP_STOP   = 3'd3,
      OP_TX     = 3'd4,
      OP_RX     = 3'd5,
      OP_ACK    = 3'd6
   } op_e;

   localparam int NUM_CMD = 5;
endpackage

// File: rtl/i2cs_qtick.sv
module i2cs_qtick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             restart_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (restart_i || tick_o)  cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

   // R1: with a non-zero divider, ticks are never back to back
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          go_i,
   input  op_e           op_i,
   input  logic [DW-1:0] tx_i,
   input  logic          ackd_i,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          scl_low_o,
   output logic          sda_low_o,
   output logic          done_o,
   output logic          busy_o,
   output logic          restart_o,
   output logic [DW-1:0] rx_o,
   output logic          nack_o
);
   localparam int BW = $clog2(DW + 1);

   op_e           op_q;
   logic [1:0]    ph_q;
   logic [BW-1:0] bit_q;
   logic [BW-1:0] last_slot;
   logic [DW-1:0] sh_q;
   logic          is_data;

   assign busy_o    = (op_q != OP_NONE);
   assign restart_o = go_i && !busy_o;
   assign rx_o      = sh_q;
   assign is_data   = (op_q == OP_TX) || (op_q == OP_RX) || (op_q == OP_ACK);

   always_comb begin
      case (op_q)
         OP_TX:   last_slot = BW'(DW);
         OP_RX:   last_slot = BW'(DW - 1);
         default: last_slot = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_NONE;
         ph_q      <= 2'd0;
         bit_q     <= '0;
         sh_q      <= '0;
         scl_low_o <= 1'b0;
         sda_low_o <= 1'b0;
         nack_o    <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (restart_o) begin
            op_q  <= op_i;
            ph_q  <= 2'd0;
            bit_q <= '0;
            if (op_i == OP_TX) sh_q <= tx_i;
         end else if (busy_o && tick_i) begin
            case (ph_q)
               2'd0: begin
                  ph_q <= 2'd1;
                  case (op_q)
                     OP_RSTART: sda_low_o <= 1'b0;
                     OP_STOP:   sda_low_o <= 1'b1;
                     OP_TX: begin
                        scl_low_o <= 1'b1;
                        sda_low_o <= (bit_q < BW'(DW)) ? ~sh_q[DW-1] : 1'b0;
                     end
                     OP_RX: begin
                        scl_low_o <= 1'b1;
                        sda_low_o <= 1'b0;
                     end
                     OP_ACK: begin
                        scl_low_o <= 1'b1;
                        sda_low_o <= ~ackd_i;
                     end
                     default: ;
                  endcase
               end
               2'd1: begin
                  scl_low_o <= 1'b0;
                  ph_q      <= 2'd2;
               end
               2'd2: begin
                  if (scl_in) begin
                     ph_q <= 2'd3;
                     case (op_q)
                        OP_START, OP_RSTART: sda_low_o <= 1'b1;
                        OP_STOP:             sda_low_o <= 1'b0;
                        OP_TX: begin
                           if (bit_q == BW'(DW)) nack_o <= sda_in;
                           else                  sh_q   <= {sh_q[DW-2:0], 1'b0};
                        end
                        OP_RX:   sh_q <= {sh_q[DW-2:0], sda_in};
                        default: ;
                     endcase
                  end
               end
               default: begin
                  ph_q <= 2'd0;
                  if (op_q != OP_STOP) scl_low_o <= 1'b1;
                  if (bit_q == last_slot) begin
                     op_q   <= OP_NONE;
                     done_o <= 1'b1;
                  end else begin
                     bit_q <= bit_q + BW'(1);
                  end
               end
            endcase
         end
      end
   end

   // R5: during data slots SDA never moves while SCL stays released
   a_r5_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && is_data && !scl_low_o && $past(!scl_low_o)) |-> $stable(sda_low_o));
   // R9: the line drivers change only while an operation runs
   a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(scl_low_o) && $stable(sda_low_o)));
   // R13: a held-low SCL freezes the high phase
   a_r13_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ph_q == 2'd2 && !scl_in) |=> (ph_q == 2'd2));
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
   import i2cs_pkg::*;
#(
   parameter int DW      = 8,
   parameter int DIV_W   = 8,
   parameter int IN_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             req_start,
   input  logic             req_rstart,
   input  logic             req_stop,
   input  logic             req_recv,
   input  logic             req_ack,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   input  logic             ack_data,
   input  logic             wcol_clr,
   input  logic             irq_clr,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic [DW-1:0]    rd_data,
   output logic             ack_stat,
   output logic [4:0]       cmd_bits,
   output logic             tx_busy,
   output logic             idle,
   output logic             wcol,
   output logic             irq,
   output logic             st_start,
   output logic             st_stop,
   output logic             bus_free
);
   localparam int NREQ = NUM_CMD + 1;

   if (DW < 2)                      begin : g_bad_dw   $error("DW must be at least 2");  end
   if (DIV_W < 1)                   begin : g_bad_div  $error("DIV_W must be positive"); end
   if (IN_SYNC < 0 || IN_SYNC > 4)  begin : g_bad_sync $error("IN_SYNC out of range");   end

   logic scl_s, sda_s;
   if (IN_SYNC == 0) begin : g_nosync
      assign scl_s = scl_in;
      assign sda_s = sda_in;
   end else begin : g_sync
      logic [IN_SYNC-1:0] scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_r <= '1;
            sda_r <= '1;
         end else begin
            scl_r[0] <= scl_in;
            sda_r[0] <= sda_in;
            for (int i = 1; i < IN_SYNC; i++) begin
               scl_r[i] <= scl_r[i-1];
               sda_r[i] <= sda_r[i-1];
            end
         end
      end
      assign scl_s = scl_r[IN_SYNC-1];
      assign sda_s = sda_r[IN_SYNC-1];
   end

   logic [NREQ-1:0] reqv, sel;
   logic            accept, reject;
   op_e             go_op;
   logic [DW-1:0]   buf_q, eng_rx;
   logic            tick, restart, eng_done, eng_busy, eng_nack;

   assign reqv   = {wr_en, req_ack, req_recv, req_stop, req_rstart, req_start};
   assign sel    = reqv & (~reqv + NREQ'(1));
   assign idle   = !(tx_busy || (|cmd_bits));
   assign accept = idle && (|reqv);
   assign reject = (|reqv) && (!idle || ((reqv & ~sel) != '0));
   assign rd_data  = buf_q;
   assign bus_free = st_stop || !st_start;

   always_comb begin
      go_op = OP_NONE;
      if      (sel[0]) go_op = OP_START;
      else if (sel[1]) go_op = OP_RSTART;
      else if (sel[2]) go_op = OP_STOP;
      else if (sel[3]) go_op = OP_RX;
      else if (sel[4]) go_op = OP_ACK;
      else if (sel[5]) go_op = OP_TX;
   end

   i2cs_qtick #(.DIV_W(DIV_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_i     (div_i),
      .restart_i (restart),
      .tick_o    (tick)
   );

   i2cs_engine #(.DW(DW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .go_i      (accept),
      .op_i      (go_op),
      .tx_i      (wr_data),
      .ackd_i    (ack_data),
      .scl_in    (scl_s),
      .sda_in    (sda_s),
      .scl_low_o (scl_oe),
      .sda_low_o (sda_oe),
      .done_o    (eng_done),
      .busy_o    (eng_busy),
      .restart_o (restart),
      .rx_o      (eng_rx),
      .nack_o    (eng_nack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_bits <= '0;
         tx_busy  <= 1'b0;
         buf_q    <= '0;
         ack_stat <= 1'b0;
         wcol     <= 1'b0;
         irq      <= 1'b0;
         st_start <= 1'b0;
         st_stop  <= 1'b0;
      end else begin
         if (accept) begin
            if (sel[5]) begin
               tx_busy <= 1'b1;
               buf_q   <= wr_data;
            end else begin
               cmd_bits <= sel[4:0];
            end
         end
         if (eng_done) begin
            cmd_bits <= '0;
            tx_busy  <= 1'b0;
            if (cmd_bits[0] || cmd_bits[1]) begin
               st_start <= 1'b1;
               st_stop  <= 1'b0;
            end
            if (cmd_bits[2]) begin
               st_stop  <= 1'b1;
               st_start <= 1'b0;
            end
            if (cmd_bits[3]) buf_q    <= eng_rx;
            if (tx_busy)     ack_stat <= eng_nack;
         end
         if (reject)        wcol <= 1'b1;
         else if (wcol_clr) wcol <= 1'b0;
         if (eng_done)      irq <= 1'b1;
         else if (irq_clr)  irq <= 1'b0;
      end
   end

   // R10: one owner at a time
   a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_busy, cmd_bits}));
   // R9: a request against a busy engine raises the collision flag
   a_r9_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && (|reqv)) |=> wcol);
   // R11: completion raises the flag
   a_r11_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> irq);
   // R8: completion returns the block to idle
   a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> idle);
   // R2: START completion status
   a_r2_start_status: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && (cmd_bits[0] || cmd_bits[1])) |=> (st_start && !st_stop));
   // R3: STOP completion status
   a_r3_stop_status: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && cmd_bits[2]) |=> (st_stop && !st_start));
   // R1: engine and divider restart together
   a_r1_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> eng_busy);
endmodule

// File: tb/i2c_cond_seq_test.sv
module i2c_cond_seq_test;
   localparam int DW = 8;
   localparam int DIV_W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] div = 8'd2;
   logic req_start = 0, req_rstart = 0, req_stop = 0, req_recv = 0, req_ack = 0;
   logic wr_en = 0;
   logic [DW-1:0] wr_data = '0;
   logic ack_data = 0, wcol_clr = 0, irq_clr = 0;
   logic stretch = 0;
   logic slv_low;
   logic scl_bus, sda_bus;
   logic scl_oe, sda_oe, ack_stat, tx_busy, idle, wcol, irq, st_start, st_stop, bus_free;
   logic [DW-1:0] rd_data;
   logic [4:0] cmd_bits;

   assign scl_bus = !scl_oe && !stretch;
   assign sda_bus = !sda_oe && !slv_low;

   i2c_cond_seq uut (
      .clk(clk), .rst_n(rst_n), .div_i(div),
      .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
      .req_recv(req_recv), .req_ack(req_ack), .wr_en(wr_en), .wr_data(wr_data),
      .ack_data(ack_data), .wcol_clr(wcol_clr), .irq_clr(irq_clr),
      .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .rd_data(rd_data), .ack_stat(ack_stat), .cmd_bits(cmd_bits), .tx_busy(tx_busy),
      .idle(idle), .wcol(wcol), .irq(irq), .st_start(st_start), .st_stop(st_stop),
      .bus_free(bus_free)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // slave model: counts SCL falls since it was armed
   int falls = 0;
   int base  = 0;
   int mode  = 0;
   int rel;
   logic [7:0] rxv = '0;
   logic ackv = 1'b0;
   always @(negedge scl_bus) falls <= falls + 1;
   always_comb begin
      rel = falls - base;
      slv_low = 1'b0;
      if (mode == 1 && rel == 8) slv_low = !ackv;
      if (mode == 2 && rel >= 0 && rel < 8) slv_low = !rxv[7-rel];
   end

   // scoreboard: 0/1 data bit, 2 START, 3 STOP
   int    exp_q[$];
   string tag_q[$];

   task automatic push(int ev, string tag);
      exp_q.push_back(ev);
      tag_q.push_back(tag);
   endtask

   task automatic push_byte(logic [7:0] b, int ackbit, string tag);
      for (int i = 7; i >= 0; i--) push(int'(b[i]), tag);
      if (ackbit >= 0) push(ackbit, tag);
   endtask

   task automatic emit(int ev);
      if (exp_q.size() == 0) begin
         check(0, "R5 unexpected bus event", ev, -1);
      end else begin
         int e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(ev == e, t, ev, e);
      end
   endtask

   // bus monitor
   logic prev_scl = 1'b1, prev_sda = 1'b1, pend = 1'b0, pbit = 1'b0;
   bit   meas = 0, have_r = 0;
   int   cyc = 0, last_r = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_scl && scl_bus && (prev_sda != sda_bus)) begin
            pend = 1'b0;
            emit(sda_bus ? 3 : 2);
         end else if (!prev_scl && scl_bus) begin
            pend = 1'b1;
            pbit = sda_bus;
            if (meas && have_r)
               check(cyc - last_r == 4 * (int'(div) + 1), "R1 SCL period", cyc - last_r, 4 * (int'(div) + 1));
            last_r = cyc;
            have_r = 1;
         end else if (prev_scl && !scl_bus) begin
            if (pend) emit(int'(pbit));
            pend = 1'b0;
            if (meas && have_r)
               check(cyc - last_r == 2 * (int'(div) + 1), "R1 SCL high time", cyc - last_r, 2 * (int'(div) + 1));
         end
      end
      if (!meas) have_r = 0;
      prev_scl = scl_bus;
      prev_sda = sda_bus;
   end

   // driver: 0 start, 1 rstart, 2 stop, 3 recv, 4 ack, 5 write
   task automatic pulse(int w, logic [7:0] d);
      @(negedge clk);
      case (w)
         0: req_start  = 1'b1;
         1: req_rstart = 1'b1;
         2: req_stop   = 1'b1;
         3: req_recv   = 1'b1;
         4: req_ack    = 1'b1;
         default: begin wr_en = 1'b1; wr_data = d; end
      endcase
      @(negedge clk);
      req_start = 0; req_rstart = 0; req_stop = 0; req_recv = 0; req_ack = 0; wr_en = 0;
   endtask

   task automatic finish_op(string tag);
      int n = 0;
      while (!idle && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(idle == 1'b1, {tag, " R8 idle after op"}, int'(idle), 1);
      check(cmd_bits == 5'd0, {tag, " R8 command bits cleared"}, int'(cmd_bits), 0);
      check(irq == 1'b1, {tag, " R11 irq set"}, int'(irq), 1);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      check(irq == 1'b0, {tag, " R11 irq cleared"}, int'(irq), 0);
   endtask

   task automatic arm(int m, logic [7:0] v, logic a);
      base = falls;
      mode = m;
      rxv  = v;
      ackv = a;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(scl_oe == 0 && sda_oe == 0, "R9 reset lines released", int'({scl_oe, sda_oe}), 0);
      check(idle == 1 && wcol == 0 && irq == 0, "R8 reset idle/flags", int'({idle, wcol, irq}), 4);
      check(st_start == 0 && st_stop == 0 && bus_free == 1, "R12 reset status", int'({st_start, st_stop, bus_free}), 1);

      // START
      push(2, "R2 START on bus");
      pulse(0, 8'h00);
      check(cmd_bits == 5'b00001 && idle == 0, "R8 START bit set", int'(cmd_bits), 1);
      finish_op("R2");
      check(st_start == 1 && st_stop == 0, "R2 start status", int'({st_start, st_stop}), 2);
      check(bus_free == 0, "R12 bus busy after START", int'(bus_free), 0);
      check(scl_oe == 1 && sda_oe == 1, "R2 both lines held low", int'({scl_oe, sda_oe}), 3);

      // transmit A5, slave acks; rejected write and stop mid-op
      push_byte(8'hA5, 0, "R5 tx A5");
      arm(1, 8'h00, 1'b0);
      meas = 1;
      pulse(5, 8'hA5);
      check(tx_busy == 1 && idle == 0, "R8 tx busy", int'(tx_busy), 1);
      repeat (20) @(negedge clk);
      pulse(5, 8'h3C);
      check(wcol == 1, "R9 write while busy flags", int'(wcol), 1);
      pulse(2, 8'h00);
      check(cmd_bits == 5'd0, "R9 stop while busy dropped", int'(cmd_bits), 0);
      finish_op("R5");
      meas = 0;
      check(ack_stat == 0, "R5 ack_stat after ACK", int'(ack_stat), 0);
      check(rd_data == 8'hA5, "R9 buffer kept", int'(rd_data), 'hA5);
      check(st_stop == 0, "R9 no STOP generated", int'(st_stop), 0);
      @(negedge clk); wcol_clr = 1'b1;
      @(negedge clk); wcol_clr = 1'b0;
      check(wcol == 0, "R9 wcol cleared", int'(wcol), 0);

      // transmit 5A, slave NACKs
      push_byte(8'h5A, 1, "R5 tx 5A");
      arm(1, 8'h00, 1'b1);
      pulse(5, 8'h5A);
      finish_op("R5");
      check(ack_stat == 1, "R5 ack_stat after NACK", int'(ack_stat), 1);

      // repeated START
      push(2, "R4 repeated START");
      arm(0, 8'h00, 1'b0);
      pulse(1, 8'h00);
      check(cmd_bits == 5'b00010, "R8 RSTART bit set", int'(cmd_bits), 2);
      finish_op("R4");
      check(st_start == 1, "R4 start status", int'(st_start), 1);

      // receive C3, then ACK
      push_byte(8'hC3, -1, "R6 rx C3");
      arm(2, 8'hC3, 1'b0);
      pulse(3, 8'h00);
      repeat (10) @(negedge clk);
      check(sda_oe == 0, "R6 SDA released in receive", int'(sda_oe), 0);
      finish_op("R6");
      check(rd_data == 8'hC3, "R6 received byte", int'(rd_data), 'hC3);
      push(0, "R7 ACK drives low");
      arm(0, 8'h00, 1'b0);
      ack_data = 1'b0;
      pulse(4, 8'h00);
      check(cmd_bits == 5'b10000, "R8 ACK bit set", int'(cmd_bits), 16);
      finish_op("R7");

      // receive 3E, then NACK
      push_byte(8'h3E, -1, "R6 rx 3E");
      arm(2, 8'h3E, 1'b0);
      pulse(3, 8'h00);
      finish_op("R6");
      check(rd_data == 8'h3E, "R6 received byte 2", int'(rd_data), 'h3E);
      push(1, "R7 NACK releases");
      arm(0, 8'h00, 1'b0);
      ack_data = 1'b1;
      pulse(4, 8'h00);
      finish_op("R7");
      ack_data = 1'b0;

      // STOP
      push(3, "R3 STOP on bus");
      pulse(2, 8'h00);
      finish_op("R3");
      check(st_stop == 1 && st_start == 0, "R3 stop status", int'({st_start, st_stop}), 1);
      check(bus_free == 1, "R12 bus free after STOP", int'(bus_free), 1);
      check(scl_oe == 0 && sda_oe == 0, "R3 lines released", int'({scl_oe, sda_oe}), 0);

      // new divider, simultaneous START and write
      div = 8'd5;
      push(2, "R10 START wins");
      @(negedge clk);
      req_start = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
      @(negedge clk);
      req_start = 1'b0; wr_en = 1'b0;
      check(cmd_bits == 5'b00001 && tx_busy == 0, "R10 only START accepted", int'({tx_busy, cmd_bits}), 1);
      check(wcol == 1, "R10 loser flagged", int'(wcol), 1);
      finish_op("R10");
      check(rd_data == 8'h3E, "R10 dropped write left buffer", int'(rd_data), 'h3E);

      // transmit 81 with external SCL hold
      push_byte(8'h81, 0, "R13 tx 81 stretched");
      arm(1, 8'h00, 1'b0);
      pulse(5, 8'h81);
      repeat (3) @(negedge scl_bus);
      @(negedge clk);
      stretch = 1'b1;
      repeat (300) @(negedge clk);
      check(tx_busy == 1, "R13 held while SCL low", int'(tx_busy), 1);
      check(irq == 0, "R13 no completion while held", int'(irq), 0);
      stretch = 1'b0;
      finish_op("R13");
      check(ack_stat == 0, "R13 ack after hold", int'(ack_stat), 0);

      // transmit 0F at div 5 with timing measured
      push_byte(8'h0F, 1, "R5 tx 0F");
      arm(1, 8'h00, 1'b1);
      meas = 1;
      pulse(5, 8'h0F);
      finish_op("R1");
      meas = 0;
      check(ack_stat == 1, "R5 NACK at div 5", int'(ack_stat), 1);

      push(3, "R3 final STOP");
      pulse(2, 8'h00);
      finish_op("R3");
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R5 all expected bus events seen", exp_q.size(), 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule